// File: doc/BRIEF.md
# Programmable Logic Tile

A programmable tile of eight identical logic cells whose function is set entirely by a configuration word. The word is shifted in serially. Each cell holds the following:
- a 16-entry truth table, read through a binary multiplexer tree driven by the cell's four inputs;
- a dedicated arithmetic carry stage that chains to the next cell;
- a D flip-flop, with a bypass path and an optional output inversion.

The clock, clock enable, synchronous set and synchronous reset are shared by all eight cells.

Configuration mode is entered by raising `cfg_en`. While it is high, one configuration bit enters per clock, the flip-flops keep their contents and every cell output reads 0. When `cfg_en` falls, the configuration stays frozen. The tile then works as whatever the loaded bits describe. Examples are a bank of eight 4-input gates, an 8-bit register or an 8-bit ripple adder.

Top module: `logic_tile`

## Requirements
- R1: While `cfg_en` is high, each clock shifts `cfg_din` into a 152-bit chain, with the most significant bit first. Bit 0 of the chain is the last bit shifted in. Cell k owns chain bits [19k+18 : 19k], laid out as follows:
  - bit 19k+18: invert;
  - bit 19k+17: arithmetic;
  - bit 19k+16: bypass;
  - bits 19k+15 .. 19k: the truth table.

  While `cfg_en` is low, the chain does not change.
- R2: Cell k takes its inputs from `cell_in[4k+3:4k]`, with input 0 at bit 4k. With arithmetic clear, its function value is truth-table bit number {in3,in2,in1,in0}.
- R3: With bypass set, `cell_out[k]` follows the function value in the same cycle. With bypass clear, `cell_out[k]` shows the flip-flop, so an input change reaches it only after the next rising clock edge.
- R4: A cell flip-flop captures its function value on a rising edge while `ce` is high. It keeps its value while `ce` is low.
- R5: `set_ff` high (with `rst` and `cfg_en` low) sets every flip-flop to 1 on the next edge, whatever the level of `ce`.
- R6: `rst` high clears every flip-flop on the next edge. It wins over `set_ff`, `ce` and `cfg_en`. It leaves the configuration untouched.
- R7: With invert set, `cell_out[k]` is the complement of the value the bypass selection picks.
- R8: With arithmetic set, the function value is in0 XOR in1 XOR carry-in, and the carry to the next cell is the majority of in0, in1 and carry-in. Eight such cells add two 8-bit words. The sum appears on `cell_out` and bit 8 appears on `carry_out`.
- R9: With arithmetic clear, a cell passes its carry-in unchanged to the next cell.
- R10: While `cfg_en` is high, `cell_out` is all zeros and the flip-flops keep their values, unless `rst` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tile clock |
| rst | input | 1 | Synchronous flip-flop clear, active high |
| ce | input | 1 | Shared flip-flop clock enable |
| set_ff | input | 1 | Synchronous flip-flop set, active high |
| cfg_en | input | 1 | Configuration mode, shifts the chain |
| cfg_din | input | 1 | Serial configuration bit |
| cell_in | input | 32 | Four inputs per cell, cell k at [4k+3:4k] |
| carry_in | input | 1 | Carry into cell 0 |
| cell_out | output | 8 | One output per cell |
| carry_out | output | 1 | Carry out of cell 7 |

## Verification
Two register controls can meet in one cycle: the shared set and the shared reset. The bench raises both together while the cells hold all ones in registered mode. It judges the result one edge later, where only an all-zero output is accepted. The second meeting point is a configuration reload while `ce` stays high and the inputs change. The bench first captures a known pattern, then reloads the tile. Right after `cfg_en` falls, and before any further edge, the outputs must still show that pattern.

// File: rtl/tile_pkg.sv
package tile_pkg;
  localparam int LUT_K      = 4;
  localparam int LUT_BITS   = 1 << LUT_K;
  localparam int CELL_CFG_W = LUT_BITS + 3;

  typedef struct packed {
    logic                inv;
    logic                arith;
    logic                bypass;
    logic [LUT_BITS-1:0] tbl;
  } cell_cfg_t;
endpackage

// File: rtl/cfg_chain.sv
module cfg_chain #(
  parameter int LEN = 152
) (
  input  logic           clk,
  input  logic           shift_en,
  input  logic           din,
  output logic [LEN-1:0] word
);
  always_ff @(posedge clk) begin
    if (shift_en) word <= {word[LEN-2:0], din};
  end
endmodule

// File: rtl/lut_mux_tree.sv
module lut_mux_tree
  import tile_pkg::*;
(
  input  logic [LUT_BITS-1:0] tbl,
  input  logic [LUT_K-1:0]    sel,
  output logic                y
);
  // heap of nodes: level 0 leaves at offset 0, each later level follows
  localparam int NODES = 2 * LUT_BITS - 1;
  logic [NODES-1:0] node;

  assign node[LUT_BITS-1:0] = tbl;

  for (genvar lv = 0; lv < LUT_K; lv++) begin : g_level
    localparam int OFS  = 2 * LUT_BITS - ((2 * LUT_BITS) >> lv);
    localparam int NOFS = 2 * LUT_BITS - (LUT_BITS >> lv);
    for (genvar j = 0; j < (LUT_BITS >> (lv + 1)); j++) begin : g_pair
      assign node[NOFS + j] = sel[lv] ? node[OFS + 2*j + 1] : node[OFS + 2*j];
    end
  end

  assign y = node[NODES-1];
endmodule

// File: rtl/cell_arith.sv
module cell_arith (
  input  logic use_arith,
  input  logic a,
  input  logic b,
  input  logic cin,
  input  logic lut_y,
  output logic f,
  output logic cout
);
  always_comb begin
    if (use_arith) begin
      f    = a ^ b ^ cin;
      cout = (a & b) | (a & cin) | (b & cin);
    end else begin
      f    = lut_y;
      cout = cin;
    end
  end
endmodule

// File: rtl/cell_reg.sv
module cell_reg (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  input  logic set_ff,
  input  logic ce,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)         q <= 1'b0;
    else if (hold)   q <= q;
    else if (set_ff) q <= 1'b1;
    else if (ce)     q <= d;
  end
endmodule

// File: rtl/logic_tile.sv
module logic_tile
  import tile_pkg::*;
#(
  parameter int NUM_CELLS = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       ce,
  input  logic                       set_ff,
  input  logic                       cfg_en,
  input  logic                       cfg_din,
  input  logic [NUM_CELLS*LUT_K-1:0] cell_in,
  input  logic                       carry_in,
  output logic [NUM_CELLS-1:0]       cell_out,
  output logic                       carry_out
);
  localparam int CFG_LEN = NUM_CELLS * CELL_CFG_W;

  logic [CFG_LEN-1:0]   cfg_word;
  logic [NUM_CELLS:0]   carry;
  logic [NUM_CELLS-1:0] ff_q;

  cfg_chain #(.LEN(CFG_LEN)) u_chain (
    .clk     (clk),
    .shift_en(cfg_en),
    .din     (cfg_din),
    .word    (cfg_word)
  );

  assign carry[0] = carry_in;

  for (genvar k = 0; k < NUM_CELLS; k++) begin : g_cell
    cell_cfg_t         cfg;
    logic [LUT_K-1:0]  ins;
    logic              lut_y;
    logic              fval;
    logic              picked;

    assign cfg = cell_cfg_t'(cfg_word[k*CELL_CFG_W +: CELL_CFG_W]);
    assign ins = cell_in[k*LUT_K +: LUT_K];

    lut_mux_tree u_lut (
      .tbl(cfg.tbl),
      .sel(ins),
      .y  (lut_y)
    );

    cell_arith u_arith (
      .use_arith(cfg.arith),
      .a        (ins[0]),
      .b        (ins[1]),
      .cin      (carry[k]),
      .lut_y    (lut_y),
      .f        (fval),
      .cout     (carry[k+1])
    );

    cell_reg u_reg (
      .clk   (clk),
      .rst   (rst),
      .hold  (cfg_en),
      .set_ff(set_ff),
      .ce    (ce),
      .d     (fval),
      .q     (ff_q[k])
    );

    assign picked      = cfg.bypass ? fval : ff_q[k];
    assign cell_out[k] = cfg_en ? 1'b0 : (picked ^ cfg.inv);
  end

  assign carry_out = carry[NUM_CELLS];
endmodule

// File: rtl/logic_tile_chk.sv
module logic_tile_chk #(
  parameter int NUM_CELLS = 8,
  parameter int CFG_LEN   = 152
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 ce,
  input logic                 set_ff,
  input logic                 cfg_en,
  input logic                 cfg_din,
  input logic [NUM_CELLS-1:0] cell_out,
  input logic [NUM_CELLS-1:0] ff_q,
  input logic [CFG_LEN-1:0]   cfg_word
);
  AST_CHAIN_SHIFT: assert property (@(posedge clk) disable iff (rst)
    cfg_en |=> cfg_word[0] == $past(cfg_din)); // R1

  AST_CHAIN_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !cfg_en |=> $stable(cfg_word)); // R1

  AST_CE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!cfg_en && !set_ff && !ce) |=> $stable(ff_q)); // R4

  AST_SET_ONES: assert property (@(posedge clk) disable iff (rst)
    (!cfg_en && set_ff) |=> ff_q == {NUM_CELLS{1'b1}}); // R5

  AST_RST_CLEAR: assert property (@(posedge clk)
    rst |=> ff_q == '0); // R6

  AST_CFG_QUIET: assert property (@(posedge clk) disable iff (rst)
    cfg_en |-> cell_out == '0); // R10

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    cfg_en |=> $stable(ff_q)); // R10
endmodule

bind logic_tile logic_tile_chk #(
  .NUM_CELLS(NUM_CELLS),
  .CFG_LEN  (CFG_LEN)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .ce      (ce),
  .set_ff  (set_ff),
  .cfg_en  (cfg_en),
  .cfg_din (cfg_din),
  .cell_out(cell_out),
  .ff_q    (ff_q),
  .cfg_word(cfg_word)
);

// File: tb/sim_logic_tile.sv
`timescale 1ns/1ps
module sim_logic_tile;
  localparam int N    = 8;
  localparam int CW   = 19;
  localparam int LEN  = N * CW;

  logic         clk = 1'b0;
  logic         rst, ce, set_ff, cfg_en, cfg_din, carry_in;
  logic [4*N-1:0] cell_in;
  logic [N-1:0] cell_out;
  logic         carry_out;

  int n_chk = 0;
  int n_err = 0;

  logic [15:0] luts [N];
  logic        inv_b;

  always #4 clk = ~clk;

  logic_tile #(.NUM_CELLS(N)) u0 (
    .clk(clk), .rst(rst), .ce(ce), .set_ff(set_ff), .cfg_en(cfg_en),
    .cfg_din(cfg_din), .cell_in(cell_in), .carry_in(carry_in),
    .cell_out(cell_out), .carry_out(carry_out)
  );

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // fill luts[] with per-cell tables and shift the whole word in
  task automatic load_cfg(input bit arith, input bit byp, input bit inv);
    logic [LEN-1:0] w;
    for (int k = 0; k < N; k++) w[k*CW +: CW] = {inv, arith, byp, luts[k]};
    inv_b  = inv;
    cfg_en = 1'b1;
    for (int i = LEN - 1; i >= 0; i--) begin
      cfg_din = w[i];
      #1;
      if (i == LEN / 2) check(cell_out == 8'h00, "R10 quiet during load", {8'h0, cell_out}, 16'h0);
      @(negedge clk);
    end
    cfg_en = 1'b0;
  endtask

  function automatic logic [4*N-1:0] spread(input int v);
    logic [4*N-1:0] r;
    for (int k = 0; k < N; k++) r[4*k +: 4] = 4'((v + k) & 15);
    return r;
  endfunction

  function automatic logic [N-1:0] expect_out(input int v);
    logic [N-1:0] r;
    for (int k = 0; k < N; k++) r[k] = luts[k][(v + k) & 15] ^ inv_b;
    return r;
  endfunction

  task automatic set_all(input logic [15:0] t);
    for (int k = 0; k < N; k++) luts[k] = t;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [N-1:0] prev;
    rst = 1'b1; ce = 1'b0; set_ff = 1'b0; cfg_en = 1'b1; cfg_din = 1'b0;
    carry_in = 1'b0; cell_in = '0; inv_b = 1'b0;
    repeat (3) @(negedge clk);
    check(cell_out == 8'h00, "R10 reset state", {8'h0, cell_out}, 16'h0);
    rst = 1'b0;
    cfg_en = 1'b0;

    // R1 R2 R3: mixed per-cell tables, bypass
    for (int k = 0; k < N; k++) luts[k] = (k % 2 == 0) ? 16'hAAAA : 16'h0001;
    load_cfg(1'b0, 1'b1, 1'b0);
    for (int v = 0; v < 16; v++) begin
      cell_in = spread(v); #1;
      check(cell_out == expect_out(v), "R1 R2 R3 mixed bypass", {8'h0, cell_out}, {8'h0, expect_out(v)});
      @(negedge clk);
    end

    // R2 R3 R4: AND then NOR, registered
    for (int t = 0; t < 2; t++) begin
      set_all(t == 0 ? 16'h8000 : 16'h0001);
      ce = 1'b0;
      load_cfg(1'b0, 1'b0, 1'b0);
      ce = 1'b1;
      cell_in = spread(15); @(negedge clk);
      prev = expect_out(15);
      for (int v = 0; v < 16; v++) begin
        cell_in = spread(v); #1;
        check(cell_out == prev, "R3 registered waits for edge", {8'h0, cell_out}, {8'h0, prev});
        @(negedge clk);
        check(cell_out == expect_out(v), "R2 R4 registered sweep", {8'h0, cell_out}, {8'h0, expect_out(v)});
        prev = expect_out(v);
      end
      // R4 hold with ce low
      ce = 1'b0;
      cell_in = spread(3);
      @(negedge clk);
      check(cell_out == prev, "R4 hold with ce low", {8'h0, cell_out}, {8'h0, prev});
    end

    // R10: reload while ce high keeps flip-flops
    set_all(16'hAAAA);
    load_cfg(1'b0, 1'b0, 1'b0);
    ce = 1'b1;
    for (int k = 0; k < N; k++) cell_in[4*k +: 4] = {3'b000, 1'((8'hA5 >> k) & 1)};
    @(negedge clk);
    check(cell_out == 8'hA5, "R4 capture pattern", {8'h0, cell_out}, 16'h00A5);
    cell_in = '0;
    load_cfg(1'b0, 1'b0, 1'b0);
    #1;
    check(cell_out == 8'hA5, "R10 flops held across reload", {8'h0, cell_out}, 16'h00A5);
    ce = 1'b0;
    @(negedge clk);

    // R5 set, R6 reset priority
    set_ff = 1'b1; @(negedge clk);
    check(cell_out == 8'hFF, "R5 set with ce low", {8'h0, cell_out}, 16'h00FF);
    rst = 1'b1; @(negedge clk);
    check(cell_out == 8'h00, "R6 reset beats set", {8'h0, cell_out}, 16'h0000);
    set_ff = 1'b0; rst = 1'b0;
    ce = 1'b1; cell_in = {4*N{1'b1}}; @(negedge clk);
    check(cell_out == 8'hFF, "R4 load ones", {8'h0, cell_out}, 16'h00FF);
    rst = 1'b1; @(negedge clk);
    check(cell_out == 8'h00, "R6 reset beats ce", {8'h0, cell_out}, 16'h0000);
    rst = 1'b0; ce = 1'b0;

    // R7 invert, registered then bypass
    load_cfg(1'b0, 1'b0, 1'b1);
    #1;
    check(cell_out == 8'hFF, "R7 inverted cleared flops", {8'h0, cell_out}, 16'h00FF);
    ce = 1'b1; cell_in = {4*N{1'b1}}; @(negedge clk);
    check(cell_out == 8'h00, "R7 inverted ones", {8'h0, cell_out}, 16'h0000);
    ce = 1'b0;
    set_all(16'h0001);
    load_cfg(1'b0, 1'b1, 1'b1);
    for (int v = 0; v < 16; v++) begin
      cell_in = spread(v); #1;
      check(cell_out == expect_out(v), "R7 inverted NOR bypass", {8'h0, cell_out}, {8'h0, expect_out(v)});
      @(negedge clk);
    end

    // R9 carry pass-through with arithmetic clear
    for (int c = 0; c < 2; c++) begin
      carry_in = 1'(c); #1;
      check(carry_out == 1'(c), "R9 carry passes", {15'h0, carry_out}, 16'(c));
      @(negedge clk);
    end

    // R8 8-bit adder
    set_all(16'h0000);
    load_cfg(1'b1, 1'b1, 1'b0);
    for (int bi = 0; bi < 5; bi++) begin
      logic [7:0] b;
      b = (bi == 0) ? 8'h00 : (bi == 1) ? 8'h01 : (bi == 2) ? 8'h55 : (bi == 3) ? 8'h80 : 8'hFF;
      for (int a = 0; a < 256; a++) begin
        for (int c = 0; c < 2; c++) begin
          logic [8:0] sum;
          for (int k = 0; k < N; k++) cell_in[4*k +: 4] = {2'b00, b[k], 1'((a >> k) & 1)};
          carry_in = 1'(c);
          sum = 9'(a) + 9'(b) + 9'(c);
          #1;
          check({carry_out, cell_out} == sum, "R8 adder", {7'h0, carry_out, cell_out}, {7'h0, sum});
        end
      end
      @(negedge clk);
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule